// File: doc/BRIEF.md
# Port-Programmed Memory Bank Mapper

This block turns a 16-bit CPU address into a 19-bit physical DRAM address. The physical memory is 32 banks of 16 KB. The CPU address space is split into four 16 KB windows. A 5-bit configuration number chooses which physical bank each window reaches. Software sets the number with an I/O write: the address must have bit 15 clear and the data byte must have its two top bits set. Configurations 0 to 7 follow a fixed base table. Configurations 8 to 31 place bank N in the second window and bank 7 in the top window.

The DRAM is built as two chip groups of 16 banks each. The upper group is reached only by a CPU access to the 4000h window while configuration bit 4 is set, and a separate select output flags such accesses. Video-controller accesses skip the banking completely. For them, the two low bank bits come straight from the video side and the upper three bank bits are zero.

A build-time parameter limits how many configuration numbers the latch accepts. The 320 KB build accepts 0 to 19. The full 512 KB build accepts 0 to 31.

Top module: `bank_mapper`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the configuration to 0. After reset, windows 0000h/4000h/8000h/C000h map to banks 0/1/2/3.
- R2: An accepted write takes effect at the next rising edge. A write is accepted when `io_wr` is 1, `cpu_addr[15]` is 0, `io_data[7:6]` is 2'b11, and `io_data[4:0]` is below `NUM_CFG`. The latch then stores `io_data[4:0]`, and `io_data[5]` has no effect.
- R3: The configuration stays unchanged in these cases: `io_wr` is 0, `cpu_addr[15]` is 1, or `io_data[7:6]` is not 2'b11.
- R4: For configurations 0 to 7, windows 0000h/4000h/8000h/C000h give these banks:
  - 0: {0,1,2,3}
  - 1: {0,1,2,7}
  - 2: {4,5,6,7}
  - 3: {0,3,2,7}
  - 4: {0,4,2,3}
  - 5: {0,5,2,3}
  - 6: {0,6,2,3}
  - 7: {0,7,2,3}
- R5: For a configuration N from 8 to 31, windows 0000h/4000h/8000h/C000h give banks {0, N, 2, 7}.
- R6: `phys_addr` equals {`phys_bank`, `cpu_addr[13:0]`}, and `bank_offs` equals `cpu_addr[13:0]`. The window is `cpu_addr[15:14]`. All outputs are combinational in the same cycle as the address.
- R7: `grp1_sel` is 1 exactly when all of these hold: `vid_sel` is 0, `cpu_addr[15:14]` is 2'b01, and configuration bit 4 is 1. Otherwise it is 0.
- R8: When `vid_sel` is 1, `phys_bank` is {3'b000, `vid_bank`} whatever the configuration, and `grp1_sel` is 0.
- R9: With `NUM_CFG`=20 (the 320 KB build), accepted writes carrying 20 to 31 leave the configuration unchanged, while 8 to 19 load normally. With the default `NUM_CFG`=32, every number loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_data | input | 8 | I/O write data |
| cpu_addr | input | 16 | CPU address; bit 15 qualifies I/O writes, bits 15:14 pick the window |
| vid_sel | input | 1 | 1 = video-controller access, 0 = CPU access |
| vid_bank | input | 2 | Low bank bits supplied by the video side |
| phys_addr | output | 19 | Physical DRAM address |
| phys_bank | output | 5 | Physical bank number |
| bank_offs | output | 14 | Offset inside the bank |
| grp1_sel | output | 1 | Selects the upper DRAM chip group |

## Verification
The bench loads every configuration from 0 to 31 and reads all four windows of each one. This separates the irregular base table, the uniform extended table, and the boundary at 8 where the top window changes source. I/O writes are tried with bit 15 set, with each non-11 top-bit pattern, and with bit 5 toggled, so the latch decode is tested apart from the table. A second instance built for 320 KB receives the numbers 19 and 20 and a random mix. Seeded random traffic also interleaves video and CPU accesses and checks the group select at every window.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
    localparam int ADDR_W   = 16;
    localparam int WIN_W    = 2;
    localparam int OFFS_W   = ADDR_W - WIN_W;
    localparam int CFG_W    = 5;
    localparam int BANK_W   = 5;
    localparam int PHYS_W   = BANK_W + OFFS_W;
    localparam int VBANK_W  = 2;
    localparam int NUM_WIN  = 1 << WIN_W;
    localparam int BASE_CFG = 8;
    localparam int GRP_BIT  = BANK_W - 1;

    typedef logic [CFG_W-1:0]  cfg_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [OFFS_W-1:0] offs_t;

    typedef enum logic [WIN_W-1:0] {
        WIN_LOW  = 2'd0,
        WIN_SWAP = 2'd1,
        WIN_MID  = 2'd2,
        WIN_TOP  = 2'd3
    } win_e;

    typedef struct packed {
        bank_t bank;
        offs_t offs;
    } phys_t;

    // Decode of a configuration write: strobe, address bit 15 low, data 7:6 = 11
    function automatic logic is_cfg_write(logic wr, logic a15, logic [7:0] d);
        return wr && !a15 && (d[7:6] == 2'b11);
    endfunction

    // Bank reached by one window under one configuration
    function automatic bank_t window_bank(cfg_t cfg, win_e win);
        bank_t b;
        logic  ext;
        ext = (int'(cfg) >= BASE_CFG);
        b   = '0;
        unique case (win)
            WIN_LOW:  b = (cfg == cfg_t'(2)) ? bank_t'(4) : bank_t'(0);
            WIN_SWAP: begin
                if (ext) b = bank_t'(cfg);
                else begin
                    case (cfg)
                        cfg_t'(0), cfg_t'(1): b = bank_t'(1);
                        cfg_t'(2):            b = bank_t'(5);
                        cfg_t'(3):            b = bank_t'(3);
                        default:              b = bank_t'(cfg);
                    endcase
                end
            end
            WIN_MID:  b = (cfg == cfg_t'(2)) ? bank_t'(6) : bank_t'(2);
            WIN_TOP:  b = (ext || cfg inside {cfg_t'(1), cfg_t'(2), cfg_t'(3)})
                          ? bank_t'(7) : bank_t'(3);
            default:  b = '0;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/bm_cfg_latch.sv
module bm_cfg_latch
    import bankmap_pkg::*;
#(
    parameter int NUM_CFG = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       io_wr,
    input  logic       io_a15,
    input  logic [7:0] io_data,
    output cfg_t       cfg_q
);
    logic accept;
    logic unused_bit5;

    assign unused_bit5 = io_data[5];
    assign accept = is_cfg_write(io_wr, io_a15, io_data)
                 && (int'(io_data[CFG_W-1:0]) < NUM_CFG);

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (accept) cfg_q <= io_data[CFG_W-1:0];
    end
endmodule

// File: rtl/bm_window_map.sv
module bm_window_map
    import bankmap_pkg::*;
#(
    parameter int WIN_IDX = 0
) (
    input  cfg_t  cfg,
    output bank_t bank
);
    assign bank = window_bank(cfg, win_e'(WIN_IDX[WIN_W-1:0]));
endmodule

// File: rtl/bm_phys_mux.sv
module bm_phys_mux
    import bankmap_pkg::*;
(
    input  logic               vid_sel,
    input  logic [VBANK_W-1:0] vid_bank,
    input  win_e               win,
    input  bank_t              cpu_bank,
    input  logic               cfg_hi,
    input  offs_t              offs,
    output phys_t              phys,
    output logic               grp1
);
    always_comb begin
        phys.offs = offs;
        if (vid_sel) begin
            phys.bank = {{(BANK_W-VBANK_W){1'b0}}, vid_bank};
            grp1      = 1'b0;
        end else begin
            phys.bank = cpu_bank;
            grp1      = cfg_hi && (win == WIN_SWAP);
        end
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bankmap_pkg::*;
#(
    parameter int NUM_CFG = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                io_wr,
    input  logic [7:0]          io_data,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                vid_sel,
    input  logic [VBANK_W-1:0]  vid_bank,
    output logic [PHYS_W-1:0]   phys_addr,
    output logic [BANK_W-1:0]   phys_bank,
    output logic [OFFS_W-1:0]   bank_offs,
    output logic                grp1_sel
);
    cfg_t  cfg_q;
    bank_t win_banks [NUM_WIN];
    win_e  win;
    phys_t phys;

    assign win = win_e'(cpu_addr[ADDR_W-1 -: WIN_W]);

    bm_cfg_latch #(.NUM_CFG(NUM_CFG)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .io_a15  (cpu_addr[ADDR_W-1]),
        .io_data (io_data),
        .cfg_q   (cfg_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        bm_window_map #(.WIN_IDX(w)) u_map (
            .cfg  (cfg_q),
            .bank (win_banks[w])
        );
    end

    bm_phys_mux u_mux (
        .vid_sel  (vid_sel),
        .vid_bank (vid_bank),
        .win      (win),
        .cpu_bank (win_banks[win]),
        .cfg_hi   (cfg_q[GRP_BIT]),
        .offs     (cpu_addr[OFFS_W-1:0]),
        .phys     (phys),
        .grp1     (grp1_sel)
    );

    assign phys_addr = phys;
    assign phys_bank = phys.bank;
    assign bank_offs = phys.offs;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
    import bankmap_pkg::*;
#(
    parameter int NUM_CFG = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               io_wr,
    input logic [7:0]         io_data,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic               vid_sel,
    input logic [PHYS_W-1:0]  phys_addr,
    input logic [BANK_W-1:0]  phys_bank,
    input logic               grp1_sel,
    input cfg_t               cfg_q
);
    logic acc;
    assign acc = io_wr && !cpu_addr[15] && (io_data[7:6] == 2'b11)
              && (int'(io_data[4:0]) < NUM_CFG);

    p_reset_r1: assert property (@(posedge clk) rst |=> (cfg_q == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        acc |=> (cfg_q == $past(io_data[4:0])));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && !cpu_addr[15] && (io_data[7:6] == 2'b11)) |=> $stable(cfg_q));

    p_top_ext_r5: assert property (@(posedge clk) disable iff (rst)
        (!vid_sel && (int'(cfg_q) >= 8) && (cpu_addr[15:14] == 2'b11))
        |-> (phys_bank == 5'd7));

    p_offset_r6: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]);

    p_grp_window_r7: assert property (@(posedge clk) disable iff (rst)
        grp1_sel |-> (!vid_sel && (cpu_addr[15:14] == 2'b01) && cfg_q[4]));

    p_video_r8: assert property (@(posedge clk) disable iff (rst)
        vid_sel |-> ((phys_bank[4:2] == 3'b000) && !grp1_sel));

    p_cfg_limit_r9: assert property (@(posedge clk) disable iff (rst)
        int'(cfg_q) < NUM_CFG);
endmodule

bind bank_mapper bank_mapper_chk #(.NUM_CFG(NUM_CFG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_wr     (io_wr),
    .io_data   (io_data),
    .cpu_addr  (cpu_addr),
    .vid_sel   (vid_sel),
    .phys_addr (phys_addr),
    .phys_bank (phys_bank),
    .grp1_sel  (grp1_sel),
    .cfg_q     (cfg_q)
);

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic [7:0]  io_data = 8'h00;
    logic [15:0] cpu_addr = 16'h0000;
    logic        vid_sel = 1'b0;
    logic [1:0]  vid_bank = 2'b00;

    logic [18:0] pa_f, pa_r;
    logic [4:0]  pb_f, pb_r;
    logic [13:0] po_f, po_r;
    logic        g_f, g_r;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int m_full = 0;
    int m_red = 0;

    always #10 clk = ~clk;

    bank_mapper u_dut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_data(io_data),
        .cpu_addr(cpu_addr), .vid_sel(vid_sel), .vid_bank(vid_bank),
        .phys_addr(pa_f), .phys_bank(pb_f), .bank_offs(po_f), .grp1_sel(g_f)
    );

    bank_mapper #(.NUM_CFG(20)) u_dut_red (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_data(io_data),
        .cpu_addr(cpu_addr), .vid_sel(vid_sel), .vid_bank(vid_bank),
        .phys_addr(pa_r), .phys_bank(pb_r), .bank_offs(po_r), .grp1_sel(g_r)
    );

    function automatic int exp_bank(int cfg, int win);
        int t0 [8] = '{0, 0, 4, 0, 0, 0, 0, 0};
        int t1 [8] = '{1, 1, 5, 3, 4, 5, 6, 7};
        int t2 [8] = '{2, 2, 6, 2, 2, 2, 2, 2};
        int t3 [8] = '{3, 7, 7, 7, 3, 3, 3, 3};
        if (cfg >= 8) begin
            case (win)
                0: return 0;
                1: return cfg;
                2: return 2;
                default: return 7;
            endcase
        end
        case (win)
            0: return t0[cfg];
            1: return t1[cfg];
            2: return t2[cfg];
            default: return t3[cfg];
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; cpu_addr = a; io_data = d;
        @(posedge clk);
        #2;
        if (!a[15] && d[7:6] == 2'b11) begin
            m_full = int'(d[4:0]);
            if (int'(d[4:0]) < 20) m_red = int'(d[4:0]);
        end
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic probe(string tag, logic [15:0] a, logic vs, logic [1:0] vb);
        int eb_f, eb_r;
        bit eg_f, eg_r;
        @(negedge clk);
        cpu_addr = a; vid_sel = vs; vid_bank = vb;
        #2;
        if (vs) begin
            eb_f = int'(vb); eb_r = int'(vb); eg_f = 0; eg_r = 0;
        end else begin
            eb_f = exp_bank(m_full, int'(a[15:14]));
            eb_r = exp_bank(m_red, int'(a[15:14]));
            eg_f = (a[15:14] == 2'b01) && (m_full >= 16);
            eg_r = (a[15:14] == 2'b01) && (m_red >= 16);
        end
        check({tag, " bank"}, int'(pb_f), eb_f);
        check({tag, " addr R6"}, int'(pa_f), (eb_f << 14) | int'(a[13:0]));
        check({tag, " offs R6"}, int'(po_f), int'(a[13:0]));
        check({tag, " grp R7"}, int'(g_f), int'(eg_f));
        check({tag, " red bank R9"}, int'(pb_r), eb_r);
        check({tag, " red grp R7"}, int'(g_r), int'(eg_r));
    endtask

    task automatic probe_all(string tag);
        for (int w = 0; w < 4; w++)
            probe(tag, 16'(w << 14) | 16'h1A5C, 1'b0, 2'b00);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset mapping 0,1,2,3
        probe_all("R1 reset");

        // R4 / R5: every configuration, all windows
        for (int c = 0; c < 32; c++) begin
            io_write(16'h7F00, 8'hC0 | 8'(c));
            probe_all(c < 8 ? "R4 base" : "R5 ext");
        end

        // R2: bit 5 ignored (E5 loads 5)
        io_write(16'h7F00, 8'hE5);
        probe_all("R2 bit5");

        // R3: rejected writes keep configuration 5
        io_write(16'h8000, 8'hC2);
        probe("R3 a15", 16'h4000, 1'b0, 2'b00);
        io_write(16'h7F00, 8'h82);
        probe("R3 d76=10", 16'h4000, 1'b0, 2'b00);
        io_write(16'h7F00, 8'h42);
        probe("R3 d76=01", 16'h4000, 1'b0, 2'b00);
        io_write(16'h7F00, 8'h02);
        probe("R3 d76=00", 16'h4000, 1'b0, 2'b00);
        @(negedge clk);
        io_data = 8'hC2; cpu_addr = 16'h7F00;
        probe("R3 no strobe", 16'h4000, 1'b0, 2'b00);

        // R9: reduced build boundary
        io_write(16'h7F00, 8'hD3);
        probe_all("R9 19");
        io_write(16'h7F00, 8'hD4);
        probe_all("R9 20");

        // R8: video bypass under extended configuration
        io_write(16'h7F00, 8'hDF);
        for (int v = 0; v < 4; v++)
            probe("R8 video", 16'h4123, 1'b1, 2'(v));

        // Random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                logic [7:0] d;
                d = 8'($urandom);
                if ($urandom_range(0, 1) == 0) d[7:6] = 2'b11;
                io_write({1'($urandom_range(0, 3) == 0), 15'($urandom)}, d);
            end
            probe("R2 R3 rand", 16'($urandom), 1'($urandom_range(0, 3) == 0),
                  2'($urandom));
        end

        // R1: reset again from a non-zero configuration
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        m_full = 0; m_red = 0;
        @(negedge clk);
        rst = 1'b0;
        probe_all("R1 rereset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule